// File: doc/BRIEF.md
# Packed SIMD Multiply Unit

This block is a two-stage pipelined multiplier that accepts a pair of 32-bit operands and a 3-bit mode code every cycle. Depending on the mode it forms one full-width 64-bit product, or several narrower lane products packed into the result words. The narrower forms are two 16-bit lanes, four 8-bit lanes, the sum of four 8-bit lanes, a 16-bit complex product (full or rounded), and per-byte multiplication in GF(2^8). Results leave as a low word and a high word, which together form an even/odd register pair.

A producer raises `in_valid` with the operands. The matching result and `out_valid` appear a fixed two clock edges later. A new operation may start every cycle. When no result is due, the result words keep their last value.

Top module: `simd_mul_unit`

## Requirements
- R1: When `in_valid` is high at rising edge N, `out_valid` is high for exactly the cycle following edge N+1 and carries that operation's result; in all other cases `out_valid` is low.
- R2: Reset (`rst_n` low, asynchronous) clears `out_valid`, `res_lo` and `res_hi` to zero. Outside reset, `res_lo` and `res_hi` change only in a cycle where `out_valid` is high; operand changes while `in_valid` is low have no effect on them.
- R3: Mode code 0 forms the 64-bit product of `src_a` and `src_b`, with the low half on `res_lo` and the high half on `res_hi`. `is_signed` = 1 selects two's-complement operands and 0 selects unsigned operands.
- R4: Mode code 1 multiplies the low 16-bit halves into a 32-bit `res_lo`, and the high 16-bit halves into a 32-bit `res_hi`. Signedness follows `is_signed`.
- R5: Mode code 2 multiplies byte k of `src_a` by byte k of `src_b` (k = 0..3, byte 0 in bits 7:0). Signedness follows `is_signed`. The 16-bit products of bytes 0 and 1 go to `res_lo` (byte 0 in bits 15:0), and those of bytes 2 and 3 go to `res_hi` in the same arrangement.
- R6: Mode code 3 puts the 32-bit sum of the four byte products of R5 on `res_lo` and drives `res_hi` to zero.
- R7: Mode code 4 takes the real part from bits 31:16 and the imaginary part from bits 15:0 of each operand, all signed 16-bit. `res_lo` = re_a*re_b − im_a*im_b and `res_hi` = re_a*im_b + im_a*re_b, each wrapped to 32 bits. `is_signed` is ignored.
- R8: Mode code 5 takes the exact real and imaginary sums of R7, adds 2^15 to each, keeps bits 31:16 and saturates to the signed 16-bit range. `res_lo` = {real, imaginary}, with real in bits 31:16, and `res_hi` is zero.
- R9: Mode code 6 multiplies byte k of `src_a` by byte k of `src_b` in GF(2^8), reduced by x^8+x^4+x^3+x^2+1 (0x11D). Each byte result goes into byte k of `res_lo`, and `res_hi` is zero.
- R10: Mode code 7 is reserved and yields zero on both result words.
- R11: Operations issued on consecutive cycles each produce their own result on consecutive cycles, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the operand inputs |
| mode | input | 3 | Operation select code (0..7) |
| is_signed | input | 1 | Signed operands for modes 0..3 |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| out_valid | output | 1 | Result words carry a fresh result |
| res_lo | output | 32 | Low (even) result word |
| res_hi | output | 32 | High (odd) result word |

## Verification
The checker relates outputs to the inputs two edges earlier. This relies on `in_valid` being held low while reset is asserted and during the two cycles after release, when the internal reset is still active. The stimulus keeps `in_valid` low from time zero until well after release, and again around the mid-run reset. Mode-dependent properties also assume that mode and operands are sampled only with `in_valid` high. The bench changes operands only at falling edges, so each issued operation is seen as a single, coherent set of values.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

  typedef enum logic [2:0] {
    MODE_WIDE     = 3'd0,
    MODE_DUAL16   = 3'd1,
    MODE_QUAD8    = 3'd2,
    MODE_QSUM     = 3'd3,
    MODE_CPLX     = 3'd4,
    MODE_CPLX_RND = 3'd5,
    MODE_GF8      = 3'd6,
    MODE_RSVD     = 3'd7
  } mul_mode_e;

endpackage

// File: rtl/simd_int_path.sv
module simd_int_path #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  output logic [2*W-1:0] wide,
  output logic [2*W-1:0] dual,
  output logic [2*W-1:0] quad,
  output logic [W-1:0]   qsum
);
  localparam int H  = W / 2;
  localparam int Q  = W / 4;
  localparam int NQ = 4;

  logic [2*W-1:0] wa, wb;
  always_comb begin
    wa   = {{W{sgn & a[W-1]}}, a};
    wb   = {{W{sgn & b[W-1]}}, b};
    wide = wa * wb;
  end

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_dual
      logic [W-1:0] ha, hb;
      always_comb begin
        ha = {{H{sgn & a[g*H+H-1]}}, a[g*H +: H]};
        hb = {{H{sgn & b[g*H+H-1]}}, b[g*H +: H]};
        dual[g*W +: W] = ha * hb;
      end
    end
  endgenerate

  logic [W-1:0] qp [NQ];
  generate
    for (g = 0; g < NQ; g++) begin : g_quad
      logic [W-1:0] qa, qb;
      always_comb begin
        qa    = {{(W-Q){sgn & a[g*Q+Q-1]}}, a[g*Q +: Q]};
        qb    = {{(W-Q){sgn & b[g*Q+Q-1]}}, b[g*Q +: Q]};
        qp[g] = qa * qb;
        quad[g*2*Q +: 2*Q] = qp[g][2*Q-1:0];
      end
    end
  endgenerate

  always_comb begin
    qsum = '0;
    for (int i = 0; i < NQ; i++) qsum = qsum + qp[i];
  end

endmodule

// File: rtl/simd_cplx_path.sv
module simd_cplx_path #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] re_full,
  output logic [W-1:0] im_full,
  output logic [W-1:0] packed_rnd
);
  localparam int H = W / 2;
  localparam logic signed [W:0] RND  = (W+1)'(1) << (H-1);
  localparam logic signed [W:0] SMAX = (W+1)'((1 << (H-1)) - 1);
  localparam logic signed [W:0] SMIN = -((W+1)'(1) << (H-1));

  function automatic logic [W:0] sext(input logic [H-1:0] v);
    return {{(H+1){v[H-1]}}, v};
  endfunction

  function automatic logic [H-1:0] rnd_sat(input logic signed [W:0] v);
    logic signed [W:0] t;
    t = (v + RND) >>> H;
    if (t > SMAX)      return SMAX[H-1:0];
    else if (t < SMIN) return SMIN[H-1:0];
    else               return t[H-1:0];
  endfunction

  logic [W:0] ar, ai, br, bi;
  logic [W:0] p_rr, p_ii, p_ri, p_ir;
  logic signed [W:0] re_x, im_x;

  always_comb begin
    ar   = sext(a[W-1:H]);
    ai   = sext(a[H-1:0]);
    br   = sext(b[W-1:H]);
    bi   = sext(b[H-1:0]);
    p_rr = ar * br;
    p_ii = ai * bi;
    p_ri = ar * bi;
    p_ir = ai * br;
    re_x = p_rr - p_ii;
    im_x = p_ri + p_ir;
    re_full    = re_x[W-1:0];
    im_full    = im_x[W-1:0];
    packed_rnd = {rnd_sat(re_x), rnd_sat(im_x)};
  end

endmodule

// File: rtl/simd_gf_path.sv
module simd_gf_path #(
  parameter int         W    = 32,
  parameter logic [8:0] POLY = 9'h11D
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod
);
  localparam int NB = W / 8;

  function automatic logic [7:0] gf_mul(input logic [7:0] x, input logic [7:0] y);
    logic [7:0] acc, sh;
    acc = '0;
    sh  = x;
    for (int i = 0; i < 8; i++) begin
      if (y[i]) acc = acc ^ sh;
      sh = sh[7] ? ((sh << 1) ^ POLY[7:0]) : (sh << 1);
    end
    return acc;
  endfunction

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_byte
      assign prod[g*8 +: 8] = gf_mul(a[g*8 +: 8], b[g*8 +: 8]);
    end
  endgenerate

endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit
  import simd_mul_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        mode,
  input  logic              is_signed,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi
);
  localparam int W = DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q, rst_meta} <= 2'b00;
    else        {rst_q, rst_meta} <= {rst_meta, 1'b1};
  end

  // stage 1: operand capture
  logic           s1_vld;
  mul_mode_e      s1_mode;
  logic           s1_sgn;
  logic [W-1:0]   s1_a, s1_b;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) s1_vld <= 1'b0;
    else        s1_vld <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_mode <= MODE_WIDE;
      s1_sgn  <= 1'b0;
      s1_a    <= '0;
      s1_b    <= '0;
    end else if (in_valid) begin
      s1_mode <= mul_mode_e'(mode);
      s1_sgn  <= is_signed;
      s1_a    <= src_a;
      s1_b    <= src_b;
    end
  end

  // stage 2: arithmetic
  logic [2*W-1:0] wide_p, dual_p, quad_p;
  logic [W-1:0]   qsum_p, cre_p, cim_p, crnd_p, gf_p;

  simd_int_path #(.W(W)) int_i (
    .a(s1_a), .b(s1_b), .sgn(s1_sgn),
    .wide(wide_p), .dual(dual_p), .quad(quad_p), .qsum(qsum_p)
  );

  simd_cplx_path #(.W(W)) cplx_i (
    .a(s1_a), .b(s1_b),
    .re_full(cre_p), .im_full(cim_p), .packed_rnd(crnd_p)
  );

  simd_gf_path #(.W(W)) gf_i (
    .a(s1_a), .b(s1_b), .prod(gf_p)
  );

  logic [W-1:0] nxt_lo, nxt_hi;
  always_comb begin
    nxt_lo = '0;
    nxt_hi = '0;
    unique case (s1_mode)
      MODE_WIDE:     {nxt_hi, nxt_lo} = wide_p;
      MODE_DUAL16:   {nxt_hi, nxt_lo} = dual_p;
      MODE_QUAD8:    {nxt_hi, nxt_lo} = quad_p;
      MODE_QSUM:     nxt_lo = qsum_p;
      MODE_CPLX:     begin nxt_lo = cre_p; nxt_hi = cim_p; end
      MODE_CPLX_RND: nxt_lo = crnd_p;
      MODE_GF8:      nxt_lo = gf_p;
      MODE_RSVD:     nxt_lo = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) out_valid <= 1'b0;
    else        out_valid <= s1_vld;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      res_lo <= '0;
      res_hi <= '0;
    end else if (s1_vld) begin
      res_lo <= nxt_lo;
      res_hi <= nxt_hi;
    end
  end

endmodule

// File: rtl/simd_mul_chk.sv
module simd_mul_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [2:0]   mode,
  input logic         is_signed,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic         out_valid,
  input logic [W-1:0] res_lo,
  input logic [W-1:0] res_hi
);

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 2));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(res_lo) && $stable(res_hi)));

  assert_wide_unsigned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode, 2) == 3'd0 && !$past(is_signed, 2)) |->
      {res_hi, res_lo} == ((2*W)'($past(src_a, 2)) * (2*W)'($past(src_b, 2))));

  assert_qsum_hi_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode, 2) == 3'd3) |-> res_hi == '0);

  assert_rnd_hi_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode, 2) == 3'd5) |-> res_hi == '0);

  assert_gf_hi_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode, 2) == 3'd6) |-> res_hi == '0);

  assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode, 2) == 3'd7) |-> (res_lo == '0 && res_hi == '0));

endmodule

bind simd_mul_unit simd_mul_chk #(.W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
  .is_signed(is_signed), .src_a(src_a), .src_b(src_b),
  .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi)
);

// File: tb/simd_mul_unit_tb_top.sv
module simd_mul_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic [2:0]  m;
    logic        s;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFE, 8'd3},  // R3 unsigned
    '{3'd0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 8'd3},  // R3 signed
    '{3'd0, 1'b1, 32'h80000000, 32'h00000002, 32'h00000000, 32'hFFFFFFFF, 8'd3},  // R3 negative
    '{3'd1, 1'b1, 32'hFFFF0003, 32'h00020005, 32'h0000000F, 32'hFFFFFFFE, 8'd4},  // R4 signed
    '{3'd1, 1'b0, 32'hFFFF8000, 32'h00020002, 32'h00010000, 32'h0001FFFE, 8'd4},  // R4 unsigned
    '{3'd2, 1'b1, 32'hFF028003, 32'h02038004, 32'h4000000C, 32'hFFFE0006, 8'd5},  // R5 signed
    '{3'd2, 1'b0, 32'hFF028003, 32'h02038004, 32'h4000000C, 32'h01FE0006, 8'd5},  // R5 unsigned
    '{3'd3, 1'b1, 32'hFF028003, 32'h02038004, 32'h00004010, 32'h00000000, 8'd6},  // R6
    '{3'd3, 1'b1, 32'hFFFFFFFF, 32'h01010101, 32'hFFFFFFFC, 32'h00000000, 8'd6},  // R6 negative sum
    '{3'd3, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0003F804, 32'h00000000, 8'd6},  // R6 unsigned max
    '{3'd4, 1'b0, 32'h00030002, 32'h00040005, 32'h00000002, 32'h00000017, 8'd7},  // R7
    '{3'd4, 1'b1, 32'h80008000, 32'h80008000, 32'h00000000, 32'h80000000, 8'd7},  // R7 wrap
    '{3'd5, 1'b0, 32'h80008000, 32'h80008000, 32'h00007FFF, 32'h00000000, 8'd8},  // R8 saturate
    '{3'd5, 1'b0, 32'h01000000, 32'h00800000, 32'h00010000, 32'h00000000, 8'd8},  // R8 half rounds up
    '{3'd5, 1'b0, 32'h00010000, 32'h7FFF0000, 32'h00000000, 32'h00000000, 8'd8},  // R8 below half
    '{3'd5, 1'b0, 32'h80008000, 32'h7FFF8000, 32'h80010001, 32'h00000000, 8'd8},  // R8 negative
    '{3'd6, 1'b0, 32'h01020300, 32'hAB8007FF, 32'hAB1D0900, 32'h00000000, 8'd9},  // R9
    '{3'd6, 1'b1, 32'h80FF0102, 32'h80015580, 32'h13FF551D, 32'h00000000, 8'd9},  // R9 reduction
    '{3'd7, 1'b1, 32'h12345678, 32'h9ABCDEF0, 32'h00000000, 32'h00000000, 8'd10}  // R10
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  mode;
  logic        is_signed;
  logic [31:0] src_a, src_b;
  logic        out_valid;
  logic [31:0] res_lo, res_hi;

  int checks;
  int errors;
  int cycles;

  simd_mul_unit #(.DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .is_signed(is_signed), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid  = 1'b1;
    mode      = v.m;
    is_signed = v.s;
    src_a     = v.a;
    src_b     = v.b;
  endtask

  task automatic idle();
    in_valid = 1'b0;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    mode = 3'd0;
    is_signed = 1'b0;
    src_a = '0;
    src_b = '0;

    // R2: reset state
    repeat (3) @(negedge clk);
    chk("R2 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R2 reset result", {res_hi, res_lo}, 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table walk: one operation, result two edges later
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      idle();
      @(negedge clk);
      chk($sformatf("R%0d vec%0d valid", VECS[i].req, i), {63'd0, out_valid}, 64'd1);
      chk($sformatf("R%0d vec%0d result", VECS[i].req, i),
          {res_hi, res_lo}, {VECS[i].hi, VECS[i].lo});
    end

    // R1: exact latency and single-cycle valid
    @(negedge clk);
    drive(VECS[3]);
    @(negedge clk);
    idle();
    chk("R1 not yet valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk("R1 valid at latency", {63'd0, out_valid}, 64'd1);
    chk("R1 result", {res_hi, res_lo}, {VECS[3].hi, VECS[3].lo});
    @(negedge clk);
    chk("R1 valid drops", {63'd0, out_valid}, 64'd0);

    // R2: operand changes with in_valid low leave results untouched
    mode = 3'd0; is_signed = 1'b0; src_a = 32'hDEADBEEF; src_b = 32'h12345678;
    repeat (3) @(negedge clk);
    chk("R2 hold while idle", {res_hi, res_lo}, {VECS[3].hi, VECS[3].lo});
    chk("R2 no valid while idle", {63'd0, out_valid}, 64'd0);

    // R11: back-to-back issue
    drive(VECS[0]);
    @(negedge clk);
    drive(VECS[16]);
    @(negedge clk);
    drive(VECS[11]);
    chk("R11 first result", {res_hi, res_lo}, {VECS[0].hi, VECS[0].lo});
    chk("R11 first valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    idle();
    chk("R11 second result", {res_hi, res_lo}, {VECS[16].hi, VECS[16].lo});
    chk("R11 second valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R11 third result", {res_hi, res_lo}, {VECS[11].hi, VECS[11].lo});
    @(negedge clk);

    // R2: asynchronous reset mid-run clears outputs
    rst_n = 1'b0;
    #1;
    chk("R2 async clear result", {res_hi, res_lo}, 64'd0);
    chk("R2 async clear valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: operation after reset release
    drive(VECS[2]);
    @(negedge clk);
    idle();
    @(negedge clk);
    chk("R3 after re-reset", {res_hi, res_lo}, {VECS[2].hi, VECS[2].lo});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule